// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register Pair

This block holds the two command words that software uses to send an interrupt to another processor. The upper word holds only the 8-bit target processor number. The lower word holds the vector, delivery kind, addressing mode, level, trigger and a two-bit target-selection code, plus one read-only busy bit. Writing the lower word starts a send. The block places a single message on a valid/ready output. That message carries the stored target and the fields that were just written.

The busy bit is set while a message waits on the output, and it controls whether new commands are accepted. A write to the lower word while busy is dropped, and the stored word and the pending message stay as they were. The busy bit clears in the cycle after the consumer accepts the message. Only the explicit-target selection code is supported. Any other code stores the written fields, sets a sticky error flag and sends nothing.

Back-pressure rules on the message port: once `msg_valid` rises, it stays high and every payload pin stays fixed until a cycle in which `msg_ready` is high. The message leaves in that cycle. `msg_valid` does not depend on `msg_ready`. Both words can be read back at any time through the combinational read port.

Top module: `ipi_cmd_regs`

## Requirements
- R1: After reset both words read as zero, `msg_valid` is low and `shorthand_err` is low.
- R2: A write to the upper word (`wr_sel`=1) stores only data bits 31:24, which read back in bits 31:24 with every other bit zero. It never starts a send.
- R3: A write to the lower word (`wr_sel`=0) while not busy, with selection code bits 19:18 equal to 0, raises `msg_valid` on the next cycle. The lower word then reads back its field bits as written, with bit 12 (busy) set.
- R4: The message carries the target from upper bits 31:24, vector from lower bits 7:0, delivery kind from bits 10:8, addressing mode from bit 11, level from bit 14 and trigger from bit 15.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and the payload stays unchanged.
- R6: In the cycle after a handshake (`msg_valid` and `msg_ready` both high), `msg_valid` is low and lower-word bit 12 reads as 0.
- R7: A lower-word write while busy is discarded. The lower word readback and the pending message are unchanged.
- R8: A lower-word write while not busy with a selection code of 1, 2 or 3 stores the fields, sets `shorthand_err` until reset, leaves bit 12 clear and sends nothing.
- R9: Lower-word bits 12, 13, 16, 17 and 31:20 always read as 0 apart from the busy bit at 12. An upper-word write while busy leaves the pending target unchanged, and the next send uses the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 lower word, 1 upper word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 lower word, 1 upper word |
| rd_data | output | 32 | Combinational readback of the selected word |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Target processor number |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery kind |
| msg_dest_mode | output | 1 | Addressing mode |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger bit |
| shorthand_err | output | 1 | Sticky unsupported-selection flag |

## Verification
The assertions assume that `msg_ready` is a known level at each clock edge, and that only one word is written per cycle, which the single write strobe with its select already guarantees. They also assume that reset is held for at least one edge before checking starts. The stimulus drives every input at the falling edge so that inputs are settled at the rising edge. It holds `msg_ready` low across long stretches so the hold rule is exercised. It writes during busy periods and biases the selection code toward zero so that sends dominate while error cases still occur.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int DEST_W   = 8;
  localparam int VEC_W    = 8;
  localparam int MODE_W   = 3;
  localparam int SH_W     = 2;

  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = WORD_W - DEST_W;

  localparam logic [WORD_W-1:0] LO_MASK =
      (((WORD_W'(1) << VEC_W) - 1) << VEC_LSB) |
      (((WORD_W'(1) << MODE_W) - 1) << MODE_LSB) |
      (WORD_W'(1) << DMODE_BIT) |
      (WORD_W'(1) << LEVEL_BIT) |
      (WORD_W'(1) << TRIG_BIT) |
      (((WORD_W'(1) << SH_W) - 1) << SH_LSB);

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              dest_mode;
    logic              level;
    logic              trigger;
  } ipi_msg_t;
endpackage

// File: rtl/ipi_dest_reg.sv
module ipi_dest_reg
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [DEST_W-1:0] dest
);
  always_ff @(posedge clk) begin
    if (!rst_n)  dest <= '0;
    else if (wr) dest <= wr_data[DEST_LSB +: DEST_W];
  end

  // R2
  hold_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(dest));
endmodule

// File: rtl/ipi_cmd_word.sv
module ipi_cmd_word
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              done,
  output logic [WORD_W-1:0] word_rd,
  output logic              busy,
  output logic              launch,
  output logic              sh_err
);
  logic [WORD_W-1:0] fields_q;
  logic [SH_W-1:0]   sh_code;
  logic              accept;
  logic              bad_sh;

  assign sh_code = wr_data[SH_LSB +: SH_W];
  assign accept  = wr && !busy;
  assign launch  = accept && (sh_code == '0);
  assign bad_sh  = accept && (sh_code != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      busy     <= 1'b0;
      sh_err   <= 1'b0;
    end else begin
      if (accept) fields_q <= wr_data & LO_MASK;
      if (launch)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (bad_sh) sh_err <= 1'b1;
    end
  end

  always_comb begin
    word_rd = fields_q;
    word_rd[BUSY_BIT] = busy;
  end

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && !done) |=> ($stable(word_rd)));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_err |=> sh_err);
  // R8
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sh |=> (!busy && sh_err));
endmodule

// File: rtl/ipi_msg_stage.sv
module ipi_msg_stage
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DEST_W-1:0] dest,
  input  logic              ready,
  output logic              valid,
  output ipi_msg_t          msg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      msg   <= '0;
    end else if (launch) begin
      valid         <= 1'b1;
      msg.dest      <= dest;
      msg.vector    <= wr_data[VEC_LSB +: VEC_W];
      msg.mode      <= wr_data[MODE_LSB +: MODE_W];
      msg.dest_mode <= wr_data[DMODE_BIT];
      msg.level     <= wr_data[LEVEL_BIT];
      msg.trigger   <= wr_data[TRIG_BIT];
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R5
  hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(msg)));
  // R6
  drain_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);
endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              rd_sel,
  output logic [31:0]       rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_dest_mode,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic              shorthand_err
);
  logic [DEST_W-1:0] dest_q;
  logic [WORD_W-1:0] lo_word;
  logic              busy;
  logic              launch;
  logic              done;
  ipi_msg_t          msg;

  assign done = msg_valid && msg_ready;

  ipi_dest_reg u_dest (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel), .wr_data(wr_data),
    .dest(dest_q));

  ipi_cmd_word u_word (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && !wr_sel), .wr_data(wr_data),
    .done(done), .word_rd(lo_word), .busy(busy), .launch(launch),
    .sh_err(shorthand_err));

  ipi_msg_stage u_msg (
    .clk(clk), .rst_n(rst_n), .launch(launch), .wr_data(wr_data),
    .dest(dest_q), .ready(msg_ready), .valid(msg_valid), .msg(msg));

  assign rd_data       = rd_sel ? {dest_q, {(WORD_W-DEST_W){1'b0}}} : lo_word;
  assign msg_dest      = msg.dest;
  assign msg_vector    = msg.vector;
  assign msg_mode      = msg.mode;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_level     = msg.level;
  assign msg_trigger   = msg.trigger;

  // R3
  busy_tracks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == msg_valid);
endmodule

// File: tb/test_ipi_cmd_regs.sv
module test_ipi_cmd_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, msg_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic msg_valid, msg_dest_mode, msg_level, msg_trigger, shorthand_err;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_mode;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ipi_cmd_regs i_ipi_cmd_regs (.*);

  localparam logic [31:0] FMASK = 32'h000C_CFFF;

  // behavioural reference
  logic [31:0] m_lo = 0, m_hi = 0;
  logic m_valid = 0, m_err = 0;
  logic [7:0] m_dest = 0, m_vec = 0;
  logic [2:0] m_mode = 0;
  logic m_dm = 0, m_lvl = 0, m_trg = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_valid = 0; m_err = 0;
      m_dest = 0; m_vec = 0; m_mode = 0; m_dm = 0; m_lvl = 0; m_trg = 0;
    end else begin
      if (m_valid && msg_ready) m_valid = 0;
      else if (wr_en && !wr_sel && !m_valid) begin
        m_lo = wr_data & FMASK;
        if (wr_data[19:18] == 0) begin
          m_valid = 1; m_dest = m_hi[31:24]; m_vec = wr_data[7:0];
          m_mode = wr_data[10:8]; m_dm = wr_data[11];
          m_lvl = wr_data[14]; m_trg = wr_data[15];
        end else m_err = 1;
      end
      if (wr_en && wr_sel) m_hi = wr_data & 32'hFF00_0000;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check("R3 valid", 32'(msg_valid), 32'(m_valid));
    check("R8 err", 32'(shorthand_err), 32'(m_err));
    if (rd_sel) check("R2 hi readback", rd_data, m_hi);
    else check("R9 lo readback", rd_data, m_lo | (32'(m_valid) << 12));
    if (m_valid) begin
      check("R4 dest", 32'(msg_dest), 32'(m_dest));
      check("R4 vector", 32'(msg_vector), 32'(m_vec));
      check("R4 mode", 32'(msg_mode), 32'(m_mode));
      check("R4 flags", {29'd0, msg_dest_mode, msg_level, msg_trigger},
            {29'd0, m_dm, m_lvl, m_trg});
    end
  endtask

  task automatic tick(logic we, logic sel, logic [31:0] d, logic rdy, logic rs);
    @(negedge clk);
    if (rst_n) compare_model();
    wr_en = we; wr_sel = sel; wr_data = d; msg_ready = rdy; rd_sel = rs;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(0, 0, 0, 0, 0);
    check("R1 lo", rd_data, 0);
    check("R1 valid/err", {30'd0, msg_valid, shorthand_err}, 0);
    tick(0, 0, 0, 0, 1);
    check("R1 hi", rd_data, 0);
    tick(1, 1, 32'hA512_3456, 0, 1);
    tick(0, 0, 0, 0, 1);
    check("R2 hi masked", rd_data, 32'hA500_0000);
    check("R2 no send", 32'(msg_valid), 0);
    tick(1, 0, 32'h8000_7D41, 0, 0);
    tick(0, 0, 0, 0, 0);
    check("R3 lo busy", rd_data, 32'h0000_5D41);
    check("R4 msg", {msg_dest, msg_vector, 5'd0, msg_mode, 5'd0, msg_dest_mode,
          msg_level, msg_trigger}, {8'hA5, 8'h41, 5'd0, 3'd5, 5'd0, 3'b110});
    tick(1, 0, 32'h0000_8077, 0, 0);
    tick(1, 1, 32'h3C00_0000, 0, 0);
    check("R7 lo kept", rd_data, 32'h0000_5D41);
    check("R7 msg kept", 32'(msg_vector), 32'h41);
    tick(0, 0, 0, 0, 0);
    check("R9 dest kept", 32'(msg_dest), 32'hA5);
    check("R5 still valid", 32'(msg_valid), 1);
    tick(0, 0, 0, 1, 0);
    tick(0, 0, 0, 0, 0);
    check("R6 drained", 32'(msg_valid), 0);
    check("R6 busy clear", rd_data, 32'h0000_4D41);
    tick(1, 0, 32'h0004_1022, 1, 0);
    tick(0, 0, 0, 1, 0);
    check("R8 err set", 32'(shorthand_err), 1);
    check("R8 no send", 32'(msg_valid), 0);
    check("R8 stored", rd_data, 32'h0004_0022);
    tick(1, 0, 32'h0000_0010, 0, 0);
    tick(0, 0, 0, 0, 0);
    check("R9 new dest", 32'(msg_dest), 32'h3C);
    check("R8 sticky", 32'(shorthand_err), 1);
    tick(0, 0, 0, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 5 != 0) d[19:18] = 2'b00;
      tick(($urandom % 3) == 0, $urandom % 2, d, ($urandom % 4) == 0, $urandom % 2);
    end
    tick(0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule